// File: doc/BRIEF.md
# Four-Rail Power Sequencing Controller

This block turns four downstream supplies on and off in a fixed order. It watches two digital supply flags: an undervoltage-ok flag and an overvoltage flag. Both come from external comparators. The supply is compliant while the undervoltage-ok flag is high and the overvoltage flag is low. When compliance holds and the sequence-enable input is active, a start timer runs. When it expires, rail A comes on. Rails B, C and D then follow, each after its own programmable delay.

When sequence-enable is released after full turn-on, the controller runs the start timer again and then takes the rails down in reverse order. The per-stage delays are reused in mirrored order. Loss of compliance drops every rail at once, at any point. A fault output reports loss of compliance. A done output reports that all four rails are on. A power-on-reset input holds the whole controller idle. Build-time parameters choose the polarity of the enables and of sequence-enable.

Top module: `rail_sequencer`

## Requirements
- R1: The supply is compliant when `uv_ok_i`=1 and `ov_i`=0. A turn-on can begin only while compliance holds and sequence-enable is active.
- R2: Compliance and sequence-enable may first both hold at clock edge E. Rail A then turns on at edge E+`start_dly_i`+1. A compliance loss during that wait turns nothing on and clears the timer, so a later start counts the full delay again.
- R3: After A comes on, B turns on `dly_b_i`+1 cycles later. C follows B after `dly_c_i`+1 cycles, and D follows C after `dly_d_i`+1 cycles. The enables only ever form the patterns none, A, AB, ABC, ABCD.
- R4: On the first clock edge that samples lost compliance, all four enables go inactive together. This applies while starting, ramping or fully on. The next turn-on waits for compliance to return.
- R5: Sequence-enable may go inactive at edge E while all four rails are on. Rail D then turns off at edge E+`start_dly_i`+1.
- R6: After D turns off, C turns off `dly_d_i`+1 cycles later. B follows C after `dly_c_i`+1 cycles, and A follows B after `dly_b_i`+1 cycles.
- R7: `fault_o` is 1 whenever compliance is lost. It returns to 0 only after compliance has been sampled on QUAL_CYCLES consecutive edges.
- R8: While `por_i`=1, all enables are inactive and `fault_o`=1. No sequencing takes place.
- R9: With EN_ACT_LOW=1, an active enable drives 0 and an inactive one drives 1. Otherwise the levels are the reverse. With SEQ_ACT_LOW=1, sequence-enable is active at 0, otherwise at 1. In `en_o`, bit 0 is rail A and bit 3 is rail D.
- R10: A delay count of 0 makes the next stage change on the very next clock edge.
- R11: If sequence-enable becomes active again during a turn-off, the turn-off completes to all-off first. A fresh turn-on then begins, with its start delay, on the following edge.
- R12: `done_o` is 1 exactly when all four rails are on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| por_i | input | 1 | Power-on-reset hold, active high |
| uv_ok_i | input | 1 | Supply above undervoltage limit |
| ov_i | input | 1 | Supply above overvoltage limit |
| seq_en_i | input | 1 | Sequence enable, polarity set by SEQ_ACT_LOW |
| start_dly_i | input | CNT_W | Start-timer threshold in cycles |
| dly_b_i | input | CNT_W | Delay between rails A and B |
| dly_c_i | input | CNT_W | Delay between rails B and C |
| dly_d_i | input | CNT_W | Delay between rails C and D |
| en_o | output | 4 | Rail enables, polarity set by EN_ACT_LOW |
| fault_o | output | 1 | Compliance fault, high when not qualified |
| done_o | output | 1 | All four rails on |

## Verification
The bench aims at the following corner cases:

- **Compliance dropout inside the start window.** It then checks that the next start counts the whole delay. A timer left uncleared would bring rail A up early.
- **Abort partway through the ramp and at full-on.** A design that walks the rails down, or drops them one cycle late, would show a stepped or delayed release.
- **Re-asserting sequence-enable midway through a turn-off.** A design that reverses on the spot would turn C back on instead of finishing at all-off and restarting through the start delay.
- **Zero delay counts.** These catch an off-by-one in which a zero count either stalls or merges two stages into one edge.
- **Exact edge on which the fault clears.** A miscounted qualification window shows up one cycle early or late.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int NUM_RAILS = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_UP    = 3'd2,
        ST_ON    = 3'd3,
        ST_STOP  = 3'd4,
        ST_DOWN  = 3'd5
    } seq_state_e;
endpackage

// File: rtl/rs_fault_qual.sv
module rs_fault_qual #(
    parameter int QUAL_CYCLES = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_i,
    input  logic comply_i,
    output logic fault_o
);
    localparam int QW = $clog2(QUAL_CYCLES + 1);

    logic          fault_d, fault_q;
    logic [QW-1:0] qcnt_d, qcnt_q;

    always_comb begin
        fault_d = fault_q;
        qcnt_d  = qcnt_q;
        if (por_i || !comply_i) begin
            fault_d = 1'b1;
            qcnt_d  = '0;
        end else if (fault_q) begin
            if (qcnt_q == QW'(QUAL_CYCLES - 1)) begin
                fault_d = 1'b0;
                qcnt_d  = '0;
            end else begin
                qcnt_d = qcnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= 1'b1;
            qcnt_q  <= '0;
        end else begin
            fault_q <= fault_d;
            qcnt_q  <= qcnt_d;
        end
    end

    assign fault_o = fault_q;

    AST_FAULT_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (!comply_i || por_i) |=> fault_q); // R7
    AST_FAULT_CLEAR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_q) |-> $past(comply_i && !por_i)); // R7
endmodule

// File: rtl/rs_seq_core.sv
module rs_seq_core #(
    parameter int CNT_W = 16
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      por_i,
    input  logic                                      comply_i,
    input  logic                                      seq_act_i,
    input  logic [rs_pkg::NUM_RAILS-1:0][CNT_W-1:0]   dly_i,
    output logic [rs_pkg::NUM_RAILS-1:0]              en_o,
    output logic                                      done_o
);
    import rs_pkg::*;

    localparam int N  = NUM_RAILS;
    localparam int SW = $clog2(N);
    localparam logic [SW-1:0] LAST = SW'(N - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [SW-1:0]    stage;
        logic [CNT_W-1:0] cnt;
        logic [N-1:0]     en;
    } regs_t;

    regs_t cur_q, nxt_d;
    logic  tmr_hit;

    // stage 0 selects the start threshold; stage k selects the delay before rail k
    assign tmr_hit = (cur_q.cnt == dly_i[cur_q.stage]);

    always_comb begin
        nxt_d = cur_q;
        if (por_i || !comply_i) begin
            nxt_d.state = ST_IDLE;
            nxt_d.stage = '0;
            nxt_d.cnt   = '0;
            nxt_d.en    = '0;
        end else begin
            unique case (cur_q.state)
                ST_IDLE: begin
                    if (seq_act_i) begin
                        nxt_d.state = ST_START;
                        nxt_d.stage = '0;
                        nxt_d.cnt   = '0;
                    end
                end
                ST_START: begin
                    if (!seq_act_i) begin
                        nxt_d.state = ST_IDLE;
                        nxt_d.cnt   = '0;
                    end else if (tmr_hit) begin
                        nxt_d.en[0] = 1'b1;
                        nxt_d.cnt   = '0;
                        nxt_d.stage = SW'(1);
                        nxt_d.state = ST_UP;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                ST_UP: begin
                    if (tmr_hit) begin
                        nxt_d.en[cur_q.stage] = 1'b1;
                        nxt_d.cnt = '0;
                        if (cur_q.stage == LAST) begin
                            nxt_d.state = ST_ON;
                            nxt_d.stage = '0;
                        end else begin
                            nxt_d.stage = cur_q.stage + 1'b1;
                        end
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                ST_ON: begin
                    if (!seq_act_i) begin
                        nxt_d.state = ST_STOP;
                        nxt_d.stage = '0;
                        nxt_d.cnt   = '0;
                    end
                end
                ST_STOP: begin
                    if (tmr_hit) begin
                        nxt_d.en[LAST] = 1'b0;
                        nxt_d.cnt      = '0;
                        nxt_d.stage    = LAST;
                        nxt_d.state    = ST_DOWN;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                ST_DOWN: begin
                    if (tmr_hit) begin
                        nxt_d.en[cur_q.stage - 1'b1] = 1'b0;
                        nxt_d.cnt = '0;
                        if (cur_q.stage == SW'(1)) begin
                            nxt_d.state = ST_IDLE;
                            nxt_d.stage = '0;
                        end else begin
                            nxt_d.stage = cur_q.stage - 1'b1;
                        end
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                default: nxt_d = '{state: ST_IDLE, stage: '0, cnt: '0, en: '0};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, stage: '0, cnt: '0, en: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign en_o   = cur_q.en;
    assign done_o = &cur_q.en;

    AST_ABORT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !comply_i |=> (cur_q.en == '0)); // R4
    AST_POR_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> (cur_q.en == '0)); // R8
    AST_RAIL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.en & (cur_q.en + 1'b1)) == '0)); // R3
    AST_ONE_RAIL_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (comply_i && !por_i) |=> ($countones(cur_q.en ^ $past(cur_q.en)) <= 1)); // R6
    AST_A_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.en[0]) |-> $past(comply_i && seq_act_i && !por_i)); // R2
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
    parameter int CNT_W       = 16,
    parameter int QUAL_CYCLES = 3000,
    parameter bit EN_ACT_LOW  = 1'b0,
    parameter bit SEQ_ACT_LOW = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          por_i,
    input  logic                          uv_ok_i,
    input  logic                          ov_i,
    input  logic                          seq_en_i,
    input  logic [CNT_W-1:0]              start_dly_i,
    input  logic [CNT_W-1:0]              dly_b_i,
    input  logic [CNT_W-1:0]              dly_c_i,
    input  logic [CNT_W-1:0]              dly_d_i,
    output logic [rs_pkg::NUM_RAILS-1:0]  en_o,
    output logic                          fault_o,
    output logic                          done_o
);
    localparam int N = rs_pkg::NUM_RAILS;

    logic                       comply;
    logic                       seq_act;
    logic [N-1:0]               en_act;
    logic [N-1:0][CNT_W-1:0]    dly;

    assign comply = uv_ok_i & ~ov_i;
    assign dly    = {dly_d_i, dly_c_i, dly_b_i, start_dly_i};

    generate
        if (SEQ_ACT_LOW) begin : g_seq_low
            assign seq_act = ~seq_en_i;
        end else begin : g_seq_high
            assign seq_act = seq_en_i;
        end
        if (EN_ACT_LOW) begin : g_en_low
            assign en_o = ~en_act;
        end else begin : g_en_high
            assign en_o = en_act;
        end
    endgenerate

    rs_seq_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_i     (por_i),
        .comply_i  (comply),
        .seq_act_i (seq_act),
        .dly_i     (dly),
        .en_o      (en_act),
        .done_o    (done_o)
    );

    rs_fault_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .por_i    (por_i),
        .comply_i (comply),
        .fault_o  (fault_o)
    );
endmodule

// File: tb/rail_sequencer_bench.sv
module rail_sequencer_bench;
    localparam int CW = 8;
    localparam int QC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          por = 1'b1;
    logic          uv_ok = 1'b1;
    logic          ov = 1'b0;
    logic          seq_n = 1'b1;
    logic [CW-1:0] ts = 8'd5, tb = 8'd3, tc = 8'd6, td = 8'd2;
    logic [3:0]    en_o;
    logic          fault_o, done_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int         at;
        logic [3:0] en;
        string      req;
    } exp_t;
    exp_t exq[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rail_sequencer #(.CNT_W(CW), .QUAL_CYCLES(QC), .EN_ACT_LOW(1'b1), .SEQ_ACT_LOW(1'b1)) u_rail_sequencer (
        .clk(clk), .rst_n(rst_n), .por_i(por), .uv_ok_i(uv_ok), .ov_i(ov), .seq_en_i(seq_n),
        .start_dly_i(ts), .dly_b_i(tb), .dly_c_i(tc), .dly_d_i(td),
        .en_o(en_o), .fault_o(fault_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic push(input int at, input logic [3:0] e, input string req);
        exp_t x;
        x.at = at; x.en = e; x.req = req;
        exq.push_back(x);
    endtask

    task automatic plan_on(input int t0, input string req);
        int t = t0 + int'(ts) + 2;
        push(t, 4'h1, req);
        t += int'(tb) + 1; push(t, 4'h3, req);
        t += int'(tc) + 1; push(t, 4'h7, req);
        t += int'(td) + 1; push(t, 4'hF, req);
    endtask

    task automatic plan_off(input int t0, input string req, output int t_end);
        int t = t0 + int'(ts) + 2;
        push(t, 4'h7, req);
        t += int'(td) + 1; push(t, 4'h3, req);
        t += int'(tc) + 1; push(t, 4'h1, req);
        t += int'(tb) + 1; push(t, 4'h0, req);
        t_end = t;
    endtask

    task automatic wait_cyc(input int c);
        while (cyc != c) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic drain();
        while (exq.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
    endtask

    // monitor: every change of the active-level enable vector must match the queue head
    logic [3:0] mon_prev = 4'h0;
    logic [3:0] mon_cur;
    exp_t       mon_e;
    initial begin
        forever begin
            @(posedge clk); #1;
            mon_cur = ~en_o;
            if (mon_cur !== mon_prev) begin
                if (exq.size() == 0) begin
                    chk(1'b0, "R3", "unexpected enable change", int'(mon_cur), int'(mon_prev));
                end else begin
                    mon_e = exq.pop_front();
                    chk(mon_cur == mon_e.en, mon_e.req, "enable pattern", int'(mon_cur), int'(mon_e.en));
                    chk(cyc == mon_e.at, mon_e.req, "change cycle", cyc, mon_e.at);
                end
                mon_prev = mon_cur;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int t, tend;
        // reset state, active-low enables idle high (R9)
        repeat (3) @(negedge clk);
        chk(en_o == 4'hF, "R9", "enables idle level in reset", int'(en_o), 4'hF);
        chk(fault_o == 1'b1, "R7", "fault in reset", int'(fault_o), 1);
        chk(done_o == 1'b0, "R12", "done in reset", int'(done_o), 0);

        // R8: por holds everything off although compliance and enable hold
        @(negedge clk); rst_n = 1'b1; seq_n = 1'b0;
        repeat (30) @(negedge clk);
        chk(en_o == 4'hF, "R8", "enables under por", int'(en_o), 4'hF);
        chk(fault_o == 1'b1, "R8", "fault under por", int'(fault_o), 1);

        // R1 R2 R3: release por -> start delay then ramp; R7 qualification edge
        @(negedge clk); por = 1'b0; t = cyc;
        plan_on(t, "R3");
        wait_cyc(t + QC - 1);
        chk(fault_o == 1'b1, "R7", "fault one edge before qualified", int'(fault_o), 1);
        wait_cyc(t + QC);
        chk(fault_o == 1'b0, "R7", "fault after qualification", int'(fault_o), 0);
        drain();
        chk(done_o == 1'b1, "R12", "done when all on", int'(done_o), 1);

        // R5 R6: off sequence
        @(negedge clk); seq_n = 1'b1; t = cyc;
        plan_off(t, "R6", tend);
        wait_cyc(t + int'(ts) + 2);
        chk(done_o == 1'b0, "R12", "done after D off", int'(done_o), 0);
        drain();
        chk(en_o == 4'hF, "R5", "all off after off sequence", int'(en_o), 4'hF);

        // R2: dropout in the start window, timer cleared
        ts = 8'd10;
        @(negedge clk); seq_n = 1'b0;
        repeat (5) @(negedge clk);
        uv_ok = 1'b0;
        repeat (20) @(negedge clk);
        chk(en_o == 4'hF, "R2", "no rail after start dropout", int'(en_o), 4'hF);
        chk(fault_o == 1'b1, "R7", "fault on undervoltage", int'(fault_o), 1);
        uv_ok = 1'b1; t = cyc;
        plan_on(t, "R2");
        drain();

        // R4: abort at full-on
        @(negedge clk); ov = 1'b1; t = cyc;
        exq.delete(); push(t + 1, 4'h0, "R4");
        drain();
        chk(fault_o == 1'b1, "R7", "fault on overvoltage", int'(fault_o), 1);
        @(negedge clk); ov = 1'b0; t = cyc;
        plan_on(t, "R1");
        // R4: abort mid-ramp once A and B are on
        wait_cyc(t + int'(ts) + 2 + int'(tb) + 2);
        @(negedge clk); ov = 1'b1; t = cyc;
        chk(~en_o == 4'h3, "R3", "partial ramp before abort", int'(~en_o), 4'h3);
        exq.delete(); push(t + 1, 4'h0, "R4");
        drain();
        @(negedge clk); ov = 1'b0; t = cyc;
        plan_on(t, "R1");
        drain();

        // R11: re-enable during the off sequence
        @(negedge clk); seq_n = 1'b1; t = cyc;
        plan_off(t, "R11", tend);
        wait_cyc(t + int'(ts) + 3);
        @(negedge clk); seq_n = 1'b0;
        plan_on(tend, "R11");
        drain();
        chk(done_o == 1'b1, "R11", "back on after re-enable", int'(done_o), 1);

        // R10: zero delays
        @(negedge clk); seq_n = 1'b1; t = cyc;
        plan_off(t, "R6", tend);
        drain();
        ts = '0; tb = '0; tc = '0; td = '0;
        @(negedge clk); seq_n = 1'b0; t = cyc;
        push(t + 2, 4'h1, "R10"); push(t + 3, 4'h3, "R10");
        push(t + 4, 4'h7, "R10"); push(t + 5, 4'hF, "R10");
        drain();
        @(negedge clk); seq_n = 1'b1; t = cyc;
        push(t + 2, 4'h7, "R10"); push(t + 3, 4'h3, "R10");
        push(t + 4, 4'h1, "R10"); push(t + 5, 4'h0, "R10");
        drain();

        // R8: por while fully on drops everything on the next edge
        @(negedge clk); seq_n = 1'b0; t = cyc;
        plan_on(t, "R1");
        drain();
        @(negedge clk); por = 1'b1; t = cyc;
        push(t + 1, 4'h0, "R8");
        drain();
        chk(fault_o == 1'b1, "R8", "fault raised by por", int'(fault_o), 1);
        chk(exq.size() == 0, "R3", "expected changes left over", exq.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule